// File: doc/BRIEF.md
# Dual-Mode Region-Aware Store Buffer

This block holds retired stores between a core's retire stage and a data cache port whose latency varies from request to request. Each store arrives with an address, data, a byte mask and one extra bit that says whether it lies inside a reorderable region. Fence markers arrive on the same input. They split the store stream into regions and take up a slot, but they never reach the cache.

Draining has two modes. A store with the region bit clear drains in strict program order: it goes out only when every older entry has completed and no other request is in flight. A store with the region bit set may go out as soon as every older entry is also a reorderable store. Requests in that case go out oldest-first but may complete in any order, so a hit can overtake an older miss. A fence, or an older store that is not reorderable, stops all younger stores until it is resolved. The sequence of stores that other agents see therefore stays consistent with total store order.

Slots are freed strictly from the head, once every older slot has been freed. A drained flag reports that the buffer is empty and idle.

Top module: `region_store_buffer`

## Requirements
- R1: After reset the buffer is empty: `drained_o` is 1, `in_ready_o` is 1 and `req_valid_o` is 0.
- R2: A store with `in_safe_i`=0 is requested only when every older entry has completed and no request is outstanding. Such stores therefore reach the cache one at a time in program order.
- R3: Reorderable stores (`in_safe_i`=1) whose older entries are all reorderable stores are requested oldest-first without waiting for earlier completions. Completions may return in any order.
- R4: At most MAX_OUT (default 4) requests are outstanding at once. A further eligible store waits until some completion arrives.
- R5: A fence is an input beat with `in_fence_i`=1. It issues no request. No store younger than the fence is requested until every store older than it has completed.
- R6: A reorderable store is never requested while an older store that is not reorderable is still incomplete.
- R7: The buffer holds DEPTH (default 8) entries, and fences count toward that. `in_ready_o` is 0 when all entries are taken, and a beat offered while `in_ready_o` is 0 is dropped and never requested.
- R8: Slots are reclaimed in program order. Completing younger entries frees no space while the oldest entry is still incomplete.
- R9: `drained_o` is 1 exactly when no entry is held and no request is outstanding.
- R10: A request carries the entry's address, data and mask, and `req_tag_o` is the entry's slot index. A completion with `cpl_valid_i`=1 and that index in `cpl_tag_i` marks the entry complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Retired store or fence offered |
| in_ready_o | output | 1 | Buffer can accept a beat |
| in_fence_i | input | 1 | Beat is a fence |
| in_safe_i | input | 1 | Store lies in a reorderable region |
| in_addr_i | input | AW | Store address |
| in_data_i | input | DW | Store data |
| in_mask_i | input | MW | Store byte mask |
| req_valid_o | output | 1 | Cache write request valid |
| req_ready_i | input | 1 | Cache accepts the request |
| req_addr_o | output | AW | Request address |
| req_data_o | output | DW | Request data |
| req_mask_o | output | MW | Request byte mask |
| req_tag_o | output | $clog2(DEPTH) | Slot index of the requesting entry |
| cpl_valid_i | input | 1 | Cache reports a request complete |
| cpl_tag_i | input | $clog2(DEPTH) | Tag of the completed request |
| drained_o | output | 1 | Buffer empty with nothing outstanding |

## Verification
The bench holds a store that is not reorderable back from completing. A design that ignores strict ordering would let the next store out early. It completes reorderable stores out of order to show that a hit passes a miss, and it keeps a fifth reorderable store waiting until a completion frees room for it. A fence placed between reorderable stores must hold the younger store until both older ones complete. A reorderable store behind a held non-reorderable store must also wait, because a design that leaks across the boundary would issue it early. A full buffer must drop an extra beat and keep its slots until the head completes. A design that frees slots out of order would raise `in_ready_o` too soon.

// File: rtl/sb_pkg.sv
package sb_pkg;
  typedef struct packed {
    logic valid;
    logic fence;
    logic safe;
    logic issued;
    logic done;
  } sb_flags_t;
endpackage

// File: rtl/sb_ring.sv
module sb_ring
  import sb_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int MW = 4,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = PW + 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  push_i,
  input  logic                  push_fence_i,
  input  logic                  push_safe_i,
  input  logic [AW-1:0]         push_addr_i,
  input  logic [DW-1:0]         push_data_i,
  input  logic [MW-1:0]         push_mask_i,
  input  logic                  issue_i,
  input  logic [PW-1:0]         issue_idx_i,
  input  logic                  cpl_i,
  input  logic [PW-1:0]         cpl_idx_i,
  input  logic [PW-1:0]         rd_idx_i,
  output logic [AW-1:0]         rd_addr_o,
  output logic [DW-1:0]         rd_data_o,
  output logic [MW-1:0]         rd_mask_o,
  output sb_flags_t [DEPTH-1:0] flags_o,
  output logic [PW-1:0]         head_o,
  output logic [CW-1:0]         count_o
);
  logic [AW-1:0] addr_q [DEPTH];
  logic [DW-1:0] data_q [DEPTH];
  logic [MW-1:0] mask_q [DEPTH];
  sb_flags_t [DEPTH-1:0] flags_q;
  logic [PW-1:0] head_q, tail_q;
  logic [CW-1:0] cnt_q;
  logic pop;

  // head leaves once its store completed, or at once if it is a fence
  assign pop = flags_q[head_q].valid && (flags_q[head_q].fence || flags_q[head_q].done);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (push_i && tail_q == PW'(i)) begin
          flags_q[i] <= '{valid: 1'b1, fence: push_fence_i, safe: push_safe_i,
                          issued: 1'b0, done: 1'b0};
        end else if (pop && head_q == PW'(i)) begin
          flags_q[i] <= '0;
        end else begin
          if (issue_i && issue_idx_i == PW'(i)) flags_q[i].issued <= 1'b1;
          if (cpl_i && cpl_idx_i == PW'(i)) flags_q[i].done <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) begin
      addr_q[tail_q] <= push_addr_i;
      data_q[tail_q] <= push_data_i;
      mask_q[tail_q] <= push_mask_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_i) tail_q <= tail_q + PW'(1);
      if (pop)    head_q <= head_q + PW'(1);
      cnt_q <= cnt_q + CW'(push_i) - CW'(pop);
    end
  end

  assign rd_addr_o = addr_q[rd_idx_i];
  assign rd_data_o = data_q[rd_idx_i];
  assign rd_mask_o = mask_q[rd_idx_i];
  assign flags_o   = flags_q;
  assign head_o    = head_q;
  assign count_o   = cnt_q;
endmodule

// File: rtl/sb_issue_sel.sv
module sb_issue_sel
  import sb_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PW = $clog2(DEPTH)
) (
  input  sb_flags_t [DEPTH-1:0] flags_i,
  input  logic [PW-1:0]         head_i,
  input  logic                  out_idle_i,
  input  logic                  out_room_i,
  output logic                  sel_valid_o,
  output logic [PW-1:0]         sel_idx_o,
  output logic                  sel_safe_o
);
  logic found, blocked, older_open;
  logic [PW-1:0] idx;
  sb_flags_t f;

  always_comb begin
    found      = 1'b0;
    blocked    = 1'b0;
    older_open = 1'b0;
    sel_idx_o  = '0;
    sel_safe_o = 1'b0;
    idx        = '0;
    f          = '0;
    for (int i = 0; i < DEPTH; i++) begin
      idx = head_i + PW'(i);
      f   = flags_i[idx];
      if (f.valid && !f.fence && !f.issued && !found) begin
        if (f.safe && !blocked) begin
          found = 1'b1; sel_idx_o = idx; sel_safe_o = 1'b1;
        end else if (!f.safe && !older_open && out_idle_i) begin
          found = 1'b1; sel_idx_o = idx; sel_safe_o = 1'b0;
        end
      end
      // fences and strict stores close the reorder window for younger entries
      if (f.valid && (f.fence || (!f.safe && !f.done))) blocked = 1'b1;
      if (f.valid && (f.fence || !f.done)) older_open = 1'b1;
    end
    sel_valid_o = found && out_room_i;
  end
endmodule

// File: rtl/sb_out_ctr.sv
module sb_out_ctr #(
  parameter int MAX_OUT = 4,
  localparam int OW = $clog2(MAX_OUT + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  input  logic          dec_i,
  output logic [OW-1:0] cnt_o,
  output logic          idle_o,
  output logic          room_o
);
  logic [OW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + OW'(inc_i) - OW'(dec_i);
  end

  assign cnt_o  = cnt_q;
  assign idle_o = (cnt_q == '0);
  assign room_o = (cnt_q < OW'(MAX_OUT));
endmodule

// File: rtl/region_store_buffer.sv
module region_store_buffer
  import sb_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int MAX_OUT = 4,
  parameter int AW      = 32,
  parameter int DW      = 32,
  parameter int MW      = 4,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = PW + 1,
  localparam int OW = $clog2(MAX_OUT + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  output logic          in_ready_o,
  input  logic          in_fence_i,
  input  logic          in_safe_i,
  input  logic [AW-1:0] in_addr_i,
  input  logic [DW-1:0] in_data_i,
  input  logic [MW-1:0] in_mask_i,
  output logic          req_valid_o,
  input  logic          req_ready_i,
  output logic [AW-1:0] req_addr_o,
  output logic [DW-1:0] req_data_o,
  output logic [MW-1:0] req_mask_o,
  output logic [PW-1:0] req_tag_o,
  input  logic          cpl_valid_i,
  input  logic [PW-1:0] cpl_tag_i,
  output logic          drained_o
);
  sb_flags_t [DEPTH-1:0] flags;
  logic [PW-1:0] head, sel_idx;
  logic [CW-1:0] occ_cnt;
  logic [OW-1:0] out_cnt;
  logic push, issue, sel_valid, sel_safe, out_idle, out_room;

  assign in_ready_o = (occ_cnt != CW'(DEPTH));
  assign push       = in_valid_i && in_ready_o;
  assign issue      = sel_valid && req_ready_i;

  sb_ring #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .MW(MW)) i_ring (
    .clk_i, .rst_ni,
    .push_i(push), .push_fence_i(in_fence_i), .push_safe_i(in_safe_i),
    .push_addr_i(in_addr_i), .push_data_i(in_data_i), .push_mask_i(in_mask_i),
    .issue_i(issue), .issue_idx_i(sel_idx),
    .cpl_i(cpl_valid_i), .cpl_idx_i(cpl_tag_i),
    .rd_idx_i(sel_idx), .rd_addr_o(req_addr_o), .rd_data_o(req_data_o),
    .rd_mask_o(req_mask_o), .flags_o(flags), .head_o(head), .count_o(occ_cnt)
  );

  sb_issue_sel #(.DEPTH(DEPTH)) i_sel (
    .flags_i(flags), .head_i(head), .out_idle_i(out_idle), .out_room_i(out_room),
    .sel_valid_o(sel_valid), .sel_idx_o(sel_idx), .sel_safe_o(sel_safe)
  );

  sb_out_ctr #(.MAX_OUT(MAX_OUT)) i_out (
    .clk_i, .rst_ni, .inc_i(issue), .dec_i(cpl_valid_i),
    .cnt_o(out_cnt), .idle_o(out_idle), .room_o(out_room)
  );

  assign req_valid_o = sel_valid;
  assign req_tag_o   = sel_idx;
  assign drained_o   = (occ_cnt == '0) && out_idle;
endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
  parameter int DEPTH   = 8,
  parameter int MAX_OUT = 4,
  localparam int CW = $clog2(DEPTH) + 1,
  localparam int OW = $clog2(MAX_OUT + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          in_valid_i,
  input logic          in_ready_o,
  input logic          req_valid_o,
  input logic          cpl_valid_i,
  input logic          drained_o,
  input logic          sel_safe,
  input logic [CW-1:0] occ_cnt,
  input logic [OW-1:0] out_cnt
);
  a_r4_out_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_cnt <= OW'(MAX_OUT));

  a_r2_strict_alone: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && !sel_safe) |-> out_cnt == '0);

  a_r7_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ_cnt <= CW'(DEPTH));

  a_r7_drop_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !in_ready_o) |=> occ_cnt <= $past(occ_cnt));

  a_r9_drained_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drained_o |-> !req_valid_o);

  a_r10_cpl_matches_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpl_valid_i |-> out_cnt != '0);
endmodule

bind region_store_buffer sb_checker #(.DEPTH(DEPTH), .MAX_OUT(MAX_OUT)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
  .req_valid_o(req_valid_o), .cpl_valid_i(cpl_valid_i), .drained_o(drained_o),
  .sel_safe(sel_safe), .occ_cnt(occ_cnt), .out_cnt(out_cnt)
);

// File: tb/test_region_store_buffer.sv
module test_region_store_buffer;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32, DW = 32, MW = 4, PW = 3;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_ready, in_fence = 0, in_safe = 0;
  logic [AW-1:0] in_addr = '0;
  logic [DW-1:0] in_data = '0;
  logic [MW-1:0] in_mask = '0;
  logic req_valid, req_ready = 1;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_data;
  logic [MW-1:0] req_mask;
  logic [PW-1:0] req_tag;
  logic cpl_valid = 0;
  logic [PW-1:0] cpl_tag = '0;
  logic drained;

  int n_chk = 0, n_err = 0, n_iss = 0;
  logic [AW-1:0] log_addr [64];
  logic [PW-1:0] log_tag [64];
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  region_store_buffer i_region_store_buffer (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_fence_i(in_fence), .in_safe_i(in_safe), .in_addr_i(in_addr),
    .in_data_i(in_data), .in_mask_i(in_mask), .req_valid_o(req_valid),
    .req_ready_i(req_ready), .req_addr_o(req_addr), .req_data_o(req_data),
    .req_mask_o(req_mask), .req_tag_o(req_tag), .cpl_valid_i(cpl_valid),
    .cpl_tag_i(cpl_tag), .drained_o(drained)
  );

  function automatic logic [DW-1:0] data_of(logic [AW-1:0] a);
    return a ^ 32'hA5A5_0000;
  endfunction
  function automatic logic [MW-1:0] mask_of(logic [AW-1:0] a);
    return 4'hF ^ a[5:2];
  endfunction

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  // handshake completes at the next posedge; inputs change at posedge+1
  always @(negedge clk) begin
    if (rst_n && req_valid && req_ready) begin
      chk(req_data == data_of(req_addr) && req_mask == mask_of(req_addr), "R10 payload",
          req_data, data_of(req_addr));
      if (n_iss < 64) begin
        log_addr[n_iss] = req_addr;
        log_tag[n_iss]  = req_tag;
      end
      n_iss++;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic push(input logic [AW-1:0] a, input logic safe, input logic fence);
    @(posedge clk); #1;
    in_valid = 1; in_safe = safe; in_fence = fence;
    in_addr = a; in_data = data_of(a); in_mask = mask_of(a);
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1;
    in_valid = 0; in_fence = 0;
  endtask

  task automatic cpl(input logic [AW-1:0] a);
    int t = -1;
    for (int i = 0; i < n_iss && i < 64; i++) if (log_addr[i] == a) t = i;
    chk(t >= 0, "R10 tag lookup", a, a);
    if (t >= 0) begin
      @(posedge clk); #1;
      cpl_valid = 1; cpl_tag = log_tag[t];
      @(posedge clk); #1;
      cpl_valid = 0;
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(drained == 1, "R1 drained", drained, 1);
    chk(in_ready == 1, "R1 ready", in_ready, 1);
    chk(req_valid == 0, "R1 no req", req_valid, 0);
  endtask

  task automatic t_strict;
    int n0 = n_iss;
    push(32'h100, 0, 0); push(32'h104, 0, 0); push(32'h108, 0, 0);
    cyc(6);
    chk(n_iss - n0 == 1, "R2 one strict out", n_iss - n0, 1);
    chk(log_addr[n0] == 32'h100, "R2 oldest first", log_addr[n0], 32'h100);
    chk(drained == 0, "R9 busy", drained, 0);
    cpl(32'h100); cyc(4);
    chk(n_iss - n0 == 2 && log_addr[n0+1] == 32'h104, "R2 second", log_addr[n0+1], 32'h104);
    cpl(32'h104); cyc(4);
    chk(n_iss - n0 == 3 && log_addr[n0+2] == 32'h108, "R2 third", log_addr[n0+2], 32'h108);
    cpl(32'h108); cyc(4);
    chk(drained == 1, "R9 drained after strict", drained, 1);
  endtask

  task automatic t_safe;
    int n0 = n_iss;
    for (int k = 0; k < 4; k++) push(32'h200 + 32'(k*4), 1, 0);
    cyc(6);
    chk(n_iss - n0 == 4, "R3 all issued", n_iss - n0, 4);
    for (int k = 0; k < 4; k++)
      chk(log_addr[n0+k] == 32'h200 + 32'(k*4), "R3 oldest-first", log_addr[n0+k], 32'h200 + k*4);
    push(32'h210, 1, 0); cyc(6);
    chk(n_iss - n0 == 4, "R4 cap holds fifth", n_iss - n0, 4);
    cpl(32'h208); cyc(4);
    chk(n_iss - n0 == 5 && log_addr[n0+4] == 32'h210, "R3 young cpl frees room", n_iss - n0, 5);
    cpl(32'h200); cpl(32'h204); cpl(32'h20C); cpl(32'h210); cyc(4);
    chk(drained == 1, "R9 drained after safe", drained, 1);
  endtask

  task automatic t_fence;
    int n0 = n_iss;
    push(32'h300, 1, 0); push(32'h304, 1, 0); push(32'h0, 0, 1); push(32'h308, 1, 0);
    cyc(6);
    chk(n_iss - n0 == 2, "R5 fence holds younger", n_iss - n0, 2);
    cpl(32'h304); cyc(4);
    chk(n_iss - n0 == 2, "R5 still held", n_iss - n0, 2);
    cpl(32'h300); cyc(4);
    chk(n_iss - n0 == 3 && log_addr[n0+2] == 32'h308, "R5 released, no fence req",
        log_addr[n0+2], 32'h308);
    cpl(32'h308); cyc(4);
    chk(drained == 1, "R9 drained after fence", drained, 1);
  endtask

  task automatic t_mixed;
    int n0 = n_iss;
    push(32'h400, 1, 0); push(32'h404, 0, 0); push(32'h408, 1, 0);
    cyc(6);
    chk(n_iss - n0 == 1, "R6 boundary holds", n_iss - n0, 1);
    cpl(32'h400); cyc(4);
    chk(n_iss - n0 == 2 && log_addr[n0+1] == 32'h404, "R6 strict next", log_addr[n0+1], 32'h404);
    cpl(32'h404); cyc(4);
    chk(n_iss - n0 == 3 && log_addr[n0+2] == 32'h408, "R6 safe after", log_addr[n0+2], 32'h408);
    cpl(32'h408); cyc(4);
  endtask

  task automatic t_full;
    int n0 = n_iss;
    bit leak = 0;
    req_ready = 0;
    for (int k = 0; k < 7; k++) push(32'h500 + 32'(k*4), 1, 0);
    push(32'h0, 0, 1);
    @(negedge clk);
    chk(in_ready == 0, "R7 full with fence", in_ready, 0);
    @(posedge clk); #1;
    in_valid = 1; in_safe = 1; in_addr = 32'h5F0; in_data = data_of(32'h5F0); in_mask = mask_of(32'h5F0);
    cyc(3);
    in_valid = 0;
    req_ready = 1; cyc(6);
    chk(n_iss - n0 == 4, "R4 cap after full", n_iss - n0, 4);
    cpl(32'h504); cpl(32'h508); cpl(32'h50C); cyc(4);
    @(negedge clk);
    chk(in_ready == 0, "R8 head blocks reclaim", in_ready, 0);
    cpl(32'h500); cyc(4);
    @(negedge clk);
    chk(in_ready == 1, "R8 head reclaimed", in_ready, 1);
    cyc(2);
    cpl(32'h510); cpl(32'h514); cpl(32'h518); cyc(6);
    for (int i = n0; i < n_iss && i < 64; i++) if (log_addr[i] == 32'h5F0) leak = 1;
    chk(n_iss - n0 == 7 && !leak, "R7 dropped beat", n_iss - n0, 7);
    chk(drained == 1, "R9 drained after full", drained, 1);
  endtask

  initial begin
    cyc(3);
    rst_n = 1;
    t_reset();
    t_strict();
    t_safe();
    t_fence();
    t_mixed();
    t_full();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      finished = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule